// File: doc/BRIEF.md
# Banked Extended-RAM Window Mapper

This block lets an 8-bit CPU with a 16-bit address bus reach a 512 MB external RAM through the CPU's 16 KB banked window at $C000-$FFFF. A ROM-bank selector normally chooses which ROM image sits in that window. When the selector holds the reserved value 255, the mapper takes over the window and splits it into two 8 KB halves. Each half has its own 16-bit page register, so program code can sit in one half while data is paged through the other.

CPU address bits 12-0 pass straight through to the RAM. Bits 13-28 come from the page register of whichever half CPU bit 13 selects. The four page bytes live in a small I/O register slot. The CPU writes them, and they can be read back. The RAM strobes are built from the decode with no more than two gate levels, gated by the clock phase PHI2. Read data returns to the CPU bus behind an output-enable signal.

A bus-phase state machine runs on the system clock. It tracks each PHI2 phase and, once per phase, holds it in one of these states: ST_PHI_LOW (PHI2 low), ST_WIN_RD and ST_WIN_WR (a window read or write), ST_REG_RD and ST_REG_WR (an access to the register slot), and ST_OFF_MAP (PHI2 high with nothing of this block selected). The transitions are as follows:
- From any state the machine goes to ST_PHI_LOW when PHI2 is low.
- From any state, while PHI2 is high, it goes to the state that matches the current access.
- Leaving ST_REG_WR for ST_PHI_LOW commits the captured byte to a page register. This is the PHI2 falling edge.

Top module: `xram_window_mapper`

## Requirements
- R1: After reset all four page bytes read back as 0, RAM chip select (active low) is high and the CPU data output-enable is low.
- R2: The RAM chip select is asserted only when the ROM-bank input equals 255, CPU address bits 15:14 are both 1 and the I/O slot is not selected. Any other bank value or address leaves every RAM strobe inactive.
- R3: The RAM chip select and strobes are inactive whenever PHI2 is low.
- R4: CPU bit 13 = 0 uses the lower page register and bit 13 = 1 uses the upper one. The RAM address is {page[15:0], cpu_addr[12:0]}.
- R5: During a selected access, RAM read enable (active low) is low exactly when R/W = 1. RAM write enable (active low) is low exactly when R/W = 0.
- R6: Register slot offsets, taken from CPU address bits 1:0, are as follows:
  - 0 is the lower window's page bits 7:0.
  - 1 is the lower window's page bits 15:8.
  - 2 is the upper window's page bits 7:0.
  - 3 is the upper window's page bits 15:8.
  
  A write takes effect at the PHI2 falling edge of a PHI2-high phase in which the slot is selected with R/W = 0.
- R7: A slot read during PHI2 high drives the stored byte onto cpu_rdata with cpu_rdata_oe high.
- R8: A window read during PHI2 high drives the RAM data onto cpu_rdata with cpu_rdata_oe high. cpu_rdata_oe is low during PHI2 low.
- R9: A write cycle with the slot not selected leaves every page byte unchanged.
- R10: Writes at $C000-range and $E000-range addresses under different page values reach distinct 29-bit RAM locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than PHI2 |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | CPU clock phase, synchronous to clk |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU R/W, 1 = read |
| cpu_wdata | input | 8 | CPU write data |
| rom_bank | input | 8 | Current ROM-bank selector value |
| io_sel | input | 1 | Register slot select from the I/O decode |
| ram_rdata | input | 8 | Data returned by the external RAM |
| ram_addr | output | 29 | External RAM address |
| ram_wdata | output | 8 | Data to the external RAM |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM read enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| cpu_rdata | output | 8 | Data driven back to the CPU |
| cpu_rdata_oe | output | 1 | Enable for cpu_rdata (models tri-state) |

## Verification
A page register commit and the first window access that depends on it can fall in adjacent system-clock cycles. The commit happens in the cycle that sees PHI2 fall. The next bus cycle's address is presented while PHI2 is still low, and its decode is combinational. The bench rewrites the lower page, then at once writes and reads back the $C000 window. It judges the result by the RAM address seen and by where the data lands in the behavioural RAM, which must be the new page and not the old one.

// File: rtl/xram_pkg.sv
package xram_pkg;

    // Bus-phase states, one per PHI2 phase classification
    typedef enum logic [2:0] {
        ST_PHI_LOW = 3'd0,
        ST_WIN_RD  = 3'd1,
        ST_WIN_WR  = 3'd2,
        ST_REG_RD  = 3'd3,
        ST_REG_WR  = 3'd4,
        ST_OFF_MAP = 3'd5
    } bus_state_e;

endpackage

// File: rtl/xram_decode.sv
module xram_decode #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 13,
    parameter int SEL_W     = 8,
    parameter int MAP_BANK  = 255,
    localparam int HI_W     = ADDR_W - PAGE_BITS,
    localparam int SUB_W    = HI_W - 2
) (
    input  logic [HI_W-1:0]  addr_hi,
    input  logic [SEL_W-1:0] rom_bank,
    input  logic             io_sel,
    output logic             win_hit,
    output logic [SUB_W-1:0] sub_sel
);

    logic bank_match;
    logic rom_area;

    // first level: compare the bank selector and detect the top quarter
    always_comb begin
        bank_match = (rom_bank == SEL_W'(MAP_BANK));
        rom_area   = &addr_hi[HI_W-1:HI_W-2];
    end

    // second level: combine; the I/O slot never overlaps the window
    always_comb begin
        win_hit = bank_match && rom_area && !io_sel;
        sub_sel = addr_hi[SUB_W-1:0];
    end

endmodule

// File: rtl/xram_bank_regs.sv
module xram_bank_regs #(
    parameter int DATA_W  = 8,
    parameter int BANK_W  = 16,
    parameter int NUM_WIN = 2,
    localparam int BYTES_PER = BANK_W / DATA_W,
    localparam int NUM_REGS  = NUM_WIN * BYTES_PER,
    localparam int OFF_W     = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [OFF_W-1:0]          wr_off,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [OFF_W-1:0]          rd_off,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_WIN*BANK_W-1:0] pages
);

    logic [DATA_W-1:0] byte_q [NUM_REGS];

    // one byte register per slot offset; offset k maps to bits k*DATA_W
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[k] <= '0;
            end else if (wr_en && (wr_off == OFF_W'(k))) begin
                byte_q[k] <= wr_data;
            end
        end
        assign pages[k*DATA_W +: DATA_W] = byte_q[k];
    end

    always_comb begin
        rd_data = byte_q[rd_off];
    end

endmodule

// File: rtl/xram_bus_fsm.sv
module xram_bus_fsm
    import xram_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              win_hit,
    input  logic              io_sel,
    input  logic              cpu_rw,
    input  logic [OFF_W-1:0]  cpu_off,
    input  logic [DATA_W-1:0] cpu_wdata,
    output bus_state_e        state,
    output logic              commit,
    output logic [OFF_W-1:0]  commit_off,
    output logic [DATA_W-1:0] commit_data
);

    bus_state_e        state_nx;
    logic [OFF_W-1:0]  off_lat;
    logic [DATA_W-1:0] data_lat;

    always_comb begin
        state_nx = ST_PHI_LOW;
        unique case (state)
            ST_PHI_LOW, ST_WIN_RD, ST_WIN_WR,
            ST_REG_RD, ST_REG_WR, ST_OFF_MAP: begin
                if (!phi2)       state_nx = ST_PHI_LOW;
                else if (io_sel) state_nx = cpu_rw ? ST_REG_RD : ST_REG_WR;
                else if (win_hit) state_nx = cpu_rw ? ST_WIN_RD : ST_WIN_WR;
                else             state_nx = ST_OFF_MAP;
            end
            default: state_nx = ST_PHI_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_PHI_LOW;
        else        state <= state_nx;
    end

    // transparent capture of slot offset and data while PHI2 is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_lat  <= '0;
            data_lat <= '0;
        end else if (phi2) begin
            off_lat  <= cpu_off;
            data_lat <= cpu_wdata;
        end
    end

    // outputs: commit on the falling PHI2 edge out of a slot write
    always_comb begin
        commit      = (state == ST_REG_WR) && !phi2;
        commit_off  = off_lat;
        commit_data = data_lat;
    end

endmodule

// File: rtl/xram_window_mapper.sv
module xram_window_mapper
    import xram_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 13,
    parameter int BANK_W    = 16,
    parameter int SEL_W     = 8,
    parameter int MAP_BANK  = 255,
    localparam int HI_W     = ADDR_W - PAGE_BITS,
    localparam int SUB_W    = HI_W - 2,
    localparam int NUM_WIN  = 1 << SUB_W,
    localparam int PHYS_W   = BANK_W + PAGE_BITS,
    localparam int OFF_W    = $clog2(NUM_WIN * BANK_W / DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [SEL_W-1:0]  rom_bank,
    input  logic              io_sel,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [PHYS_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_cs_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rdata_oe
);

    logic                      win_hit;
    logic [SUB_W-1:0]          sub_sel;
    logic [NUM_WIN*BANK_W-1:0] pages;
    logic [DATA_W-1:0]         reg_rdata;
    bus_state_e                state;
    logic                      commit;
    logic [OFF_W-1:0]          commit_off;
    logic [DATA_W-1:0]         commit_data;
    logic                      cs_act;

    xram_decode #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .SEL_W(SEL_W), .MAP_BANK(MAP_BANK)
    ) u_decode (
        .addr_hi (cpu_addr[ADDR_W-1:PAGE_BITS]),
        .rom_bank(rom_bank),
        .io_sel  (io_sel),
        .win_hit (win_hit),
        .sub_sel (sub_sel)
    );

    xram_bus_fsm #(
        .DATA_W(DATA_W), .OFF_W(OFF_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .phi2       (phi2),
        .win_hit    (win_hit),
        .io_sel     (io_sel),
        .cpu_rw     (cpu_rw),
        .cpu_off    (cpu_addr[OFF_W-1:0]),
        .cpu_wdata  (cpu_wdata),
        .state      (state),
        .commit     (commit),
        .commit_off (commit_off),
        .commit_data(commit_data)
    );

    xram_bank_regs #(
        .DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_WIN(NUM_WIN)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (commit),
        .wr_off (commit_off),
        .wr_data(commit_data),
        .rd_off (cpu_addr[OFF_W-1:0]),
        .rd_data(reg_rdata),
        .pages  (pages)
    );

    // strobes: decode AND phase, then split by direction
    always_comb begin
        cs_act    = win_hit && phi2;
        ram_cs_n  = !cs_act;
        ram_oe_n  = !(cs_act && cpu_rw);
        ram_we_n  = !(cs_act && !cpu_rw);
        ram_addr  = {pages[sub_sel*BANK_W +: BANK_W], cpu_addr[PAGE_BITS-1:0]};
        ram_wdata = cpu_wdata;
    end

    // readback toward the CPU
    always_comb begin
        cpu_rdata_oe = phi2 && cpu_rw && (win_hit || io_sel);
        cpu_rdata    = io_sel ? reg_rdata : ram_rdata;
    end

endmodule

// File: rtl/xram_window_mapper_chk.sv
module xram_window_mapper_chk
    import xram_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        phi2,
    input logic [15:0] cpu_addr,
    input logic        cpu_rw,
    input logic [7:0]  rom_bank,
    input logic        io_sel,
    input logic [28:0] ram_addr,
    input logic        ram_cs_n,
    input logic        ram_oe_n,
    input logic        ram_we_n,
    input logic        cpu_rdata_oe,
    input logic [31:0] pages,
    input bus_state_e  state
);

    // R2
    cs_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |-> (rom_bank == 8'hFF) && (cpu_addr[15:14] == 2'b11) && !io_sel);

    // R3
    cs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> ram_cs_n && ram_oe_n && ram_we_n);

    // R4
    addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |-> ram_addr[12:0] == cpu_addr[12:0]);

    // R5
    we_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_cs_n && !cpu_rw && ram_oe_n);

    // R5
    oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> !ram_cs_n && cpu_rw && ram_we_n);

    // R8
    rdata_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata_oe |-> phi2 && cpu_rw);

    // R6
    page_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pages) |-> $past(state) == ST_REG_WR);

endmodule

bind xram_window_mapper xram_window_mapper_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .phi2        (phi2),
    .cpu_addr    (cpu_addr),
    .cpu_rw      (cpu_rw),
    .rom_bank    (rom_bank),
    .io_sel      (io_sel),
    .ram_addr    (ram_addr),
    .ram_cs_n    (ram_cs_n),
    .ram_oe_n    (ram_oe_n),
    .ram_we_n    (ram_we_n),
    .cpu_rdata_oe(cpu_rdata_oe),
    .pages       (pages),
    .state       (state)
);

// File: tb/test_xram_window_mapper.sv
module test_xram_window_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  rom_bank = '0;
    logic        io_sel = 1'b0;
    logic [7:0]  ram_rdata = '0;
    logic [28:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_cs_n, ram_oe_n, ram_we_n;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;

    always #10 clk = ~clk;

    xram_window_mapper i_xram_window_mapper (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr),
        .cpu_rw(cpu_rw), .cpu_wdata(cpu_wdata), .rom_bank(rom_bank),
        .io_sel(io_sel), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe)
    );

    // behavioural RAM
    logic [7:0] mem [logic [28:0]];
    always @(posedge clk) if (!ram_cs_n && !ram_we_n) mem[ram_addr] = ram_wdata;
    always @(negedge clk) ram_rdata = mem.exists(ram_addr) ? mem[ram_addr] : 8'h00;

    // scoreboard
    localparam int K_CS = 0, K_WE = 1, K_OE = 2, K_ADDR = 3, K_RDATA = 4, K_CPUOE = 5, K_MEM = 6;
    typedef struct { int kind; logic [31:0] exp; logic [28:0] a; string req; } item_t;
    item_t sbq[$];
    event  smp_ev;
    int    total = 0, fails = 0;
    bit    done = 0;
    logic [15:0] page_lo = '0, page_hi = '0;

    task automatic expect_item(input int kind, input logic [31:0] exp,
                               input logic [28:0] a, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.a = a; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic sample();
        -> smp_ev;
        #1;
    endtask

    initial begin
        forever begin
            @(smp_ev);
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] obs;
                it = sbq.pop_front();
                case (it.kind)
                    K_CS:    obs = 32'(ram_cs_n);
                    K_WE:    obs = 32'(ram_we_n);
                    K_OE:    obs = 32'(ram_oe_n);
                    K_ADDR:  obs = 32'(ram_addr);
                    K_RDATA: obs = 32'(cpu_rdata);
                    K_CPUOE: obs = 32'(cpu_rdata_oe);
                    default: obs = mem.exists(it.a) ? 32'(mem[it.a]) : 32'hDEAD;
                endcase
                total++;
                if (obs !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, obs, it.exp);
                end
            end
        end
    end

    task automatic begin_cycle(input logic [15:0] a, input logic rw, input logic [7:0] d,
                               input logic io, input logic [7:0] bank, input bit chk_low);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_wdata = d; io_sel = io; rom_bank = bank; phi2 = 1'b0;
        repeat (2) @(negedge clk);
        if (chk_low) begin
            expect_item(K_CS, 1, '0, "R3");
            expect_item(K_CPUOE, 0, '0, "R8");
            sample();
        end
        phi2 = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_cycle();
        phi2 = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] off, input logic [7:0] d);
        begin_cycle({14'h2000, off}, 1'b0, d, 1'b1, 8'h00, 0);
        end_cycle();
        case (off)
            2'd0: page_lo[7:0]  = d;
            2'd1: page_lo[15:8] = d;
            2'd2: page_hi[7:0]  = d;
            default: page_hi[15:8] = d;
        endcase
    endtask

    task automatic reg_read(input logic [1:0] off, input logic [7:0] exp, input string req);
        begin_cycle({14'h2000, off}, 1'b1, 8'h00, 1'b1, 8'h00, 0);
        expect_item(K_RDATA, 32'(exp), '0, req);
        expect_item(K_CPUOE, 1, '0, req);
        sample();
        end_cycle();
    endtask

    task automatic win_write(input logic [15:0] a, input logic [7:0] d);
        logic [28:0] pa;
        pa = {(a[13] ? page_hi : page_lo), a[12:0]};
        begin_cycle(a, 1'b0, d, 1'b0, 8'hFF, 1);
        expect_item(K_CS, 0, '0, "R2");
        expect_item(K_WE, 0, '0, "R5");
        expect_item(K_OE, 1, '0, "R5");
        expect_item(K_ADDR, 32'(pa), '0, "R4");
        sample();
        end_cycle();
    endtask

    task automatic win_read(input logic [15:0] a, input logic [7:0] exp);
        begin_cycle(a, 1'b1, 8'h00, 1'b0, 8'hFF, 0);
        expect_item(K_OE, 0, '0, "R5");
        expect_item(K_WE, 1, '0, "R5");
        expect_item(K_RDATA, 32'(exp), '0, "R8");
        expect_item(K_CPUOE, 1, '0, "R8");
        sample();
        end_cycle();
    endtask

    task automatic print_summary();
        $display("  %0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            print_summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        expect_item(K_CS, 1, '0, "R1");
        expect_item(K_CPUOE, 0, '0, "R1");
        sample();
        for (int k = 0; k < 4; k++) reg_read(2'(k), 8'h00, "R1");

        // R6/R7: register map and readback
        reg_write(2'd0, 8'h34);
        reg_write(2'd1, 8'h12);
        reg_write(2'd2, 8'hCD);
        reg_write(2'd3, 8'hAB);
        reg_read(2'd0, 8'h34, "R6");
        reg_read(2'd1, 8'h12, "R6");
        reg_read(2'd2, 8'hCD, "R7");
        reg_read(2'd3, 8'hAB, "R7");

        // R9: write cycle without slot select is ignored
        begin_cycle(16'h4000, 1'b0, 8'hFF, 1'b0, 8'h00, 0);
        end_cycle();
        reg_read(2'd0, 8'h34, "R9");

        // R4/R10: both sub-windows
        win_write(16'hC005, 8'h5A);
        win_write(16'hE005, 8'hA5);
        // page change then immediate window access
        reg_write(2'd1, 8'h00);
        reg_write(2'd0, 8'h01);
        win_write(16'hC005, 8'h77);
        win_read(16'hC005, 8'h77);
        win_read(16'hE005, 8'hA5);

        // R2: bank 254 and off-window address give no strobes
        begin_cycle(16'hC005, 1'b0, 8'h11, 1'b0, 8'hFE, 0);
        expect_item(K_CS, 1, '0, "R2");
        expect_item(K_WE, 1, '0, "R2");
        sample();
        end_cycle();
        begin_cycle(16'h8005, 1'b0, 8'h22, 1'b0, 8'hFF, 0);
        expect_item(K_CS, 1, '0, "R2");
        sample();
        end_cycle();

        // R10: distinct physical locations hold their own data
        expect_item(K_MEM, 8'h5A, {16'h1234, 13'h0005}, "R10");
        expect_item(K_MEM, 8'hA5, {16'hABCD, 13'h0005}, "R10");
        expect_item(K_MEM, 8'h77, {16'h0001, 13'h0005}, "R10");
        sample();

        done = 1;
        print_summary();
        $finish;
    end

endmodule